// File: doc/BRIEF.md
# Serial memory bus front end

This block is the pin-side front end of a serial memory slave working in single-line mode. It brings the chip select, serial clock, serial data in and pause inputs into the system clock domain through two-flop synchronizers and detects their edges there. It samples one data bit on each rising serial clock edge, most significant bit first, and hands each completed byte to a command decoder with a one-cycle strobe. On each falling serial clock edge it drives one bit of a byte that the decoder supplies on the serial data output, which has its own output enable.

After reset the block stays inert until the select line goes from deselected to selected. A select line that is already active at reset does not count. Raising the select line aborts any partial byte. While selected, a low pause input turns off the output and freezes all shift state, so that the transfer picks up exactly where it stopped. A quad-enable configuration bit turns the pause input off, because in that mode the same pin carries data.

Top module: `spi_front_end`

## Requirements
- R1: While the synchronized chip select `cs_ni` is high (deselected), `sdo_oe_o` is 0.
- R2: After reset, no byte is delivered (`byte_valid_o` stays 0) and `sdo_oe_o` stays 0 until `cs_ni` has gone from 1 to 0. This holds even when `cs_ni` is already 0 when reset is released.
- R3: `sdi_i` is sampled on each rising edge of `sclk_i`, most significant bit first. After every eighth sampled bit, `rx_byte_o` holds the byte and `byte_valid_o` is high for exactly one system clock.
- R4: `sdo_o` changes only after a falling edge of `sclk_i`. The k-th falling edge of a byte (k = 0..7) drives bit 7-k of `tx_byte_i`, which is sampled at falling edge 0. After a select edge, `sdo_o` is 0 until the first falling edge.
- R5: While selected with `hold_ni` low and `quad_en_i` 0, `sdo_oe_o` is 0. Activity on `sclk_i` and `sdi_i` is ignored and the shift state is kept.
- R6: When `hold_ni` returns high, reception and transmission continue from the bit at which they paused.
- R7: When `quad_en_i` is 1, `hold_ni` has no effect, and `sdo_oe_o` is 1 while selected.
- R8: A rising edge of `cs_ni` discards any partially received byte. The next byte starts at bit 7.
- R9: While selected after a valid select edge and not paused, `sdo_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous to clk_i |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause, active low |
| quad_en_i | input | 1 | Quad-enable configuration bit; disables pause |
| tx_byte_i | input | DATA_W | Byte to shift out, sampled at the first falling edge of each byte |
| rx_byte_o | output | DATA_W | Last received byte |
| byte_valid_o | output | 1 | One-cycle strobe when rx_byte_o is updated |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = high impedance) |

## Verification
The bench uses the default parameters: DATA_W of 8 and two synchronizer stages. Each serial clock phase lasts eight system clocks, so every edge clears the synchronizer delay before the next one arrives. This setup covers the full bit counter wrap, the output bit order across back-to-back bytes, a pause in the middle of a byte while the serial clock keeps toggling, an aborted partial byte, and a select line held active through reset.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  parameter int unsigned SYNC_STAGES_DEF = 2;
  parameter int unsigned DATA_W_DEF      = 8;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_fe_edge.sv
module spi_fe_edge
  import spi_fe_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  output edge_t edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign edge_o.rise = lvl_i & ~prev_q;
  assign edge_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] nxt;

  assign nxt = {sh_q[DATA_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_o   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        sh_q  <= '0;
        cnt_o <= '0;
      end else if (en_i) begin
        sh_q <= nxt;
        if (cnt_o == CNT_W'(DATA_W-1)) begin
          cnt_o   <= '0;
          data_o  <= nxt;
          valid_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_o <= 1'b0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_o <= 1'b0;
    end else if (shift_i) begin
      if (cnt_q == '0) begin
        sdo_o <= data_i[DATA_W-1];
        sh_q  <= {data_i[DATA_W-2:0], 1'b0};
      end else begin
        sdo_o <= sh_q[DATA_W-1];
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      end
      cnt_q <= (cnt_q == CNT_W'(DATA_W-1)) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_front_end.sv
module spi_front_end
  import spi_fe_pkg::*;
#(
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  localparam int unsigned CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              hold_ni,
  input  logic              quad_en_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              byte_valid_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  // cs sync resets low so a select already active at reset gives no edge
  logic [3:0] pins_s;
  logic cs_s, hold_s, sclk_s, sdi_s;

  spi_fe_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) i_sync (
    .clk_i, .rst_ni,
    .d_i({cs_ni, hold_ni, sclk_i, sdi_i}),
    .q_o(pins_s)
  );
  assign {cs_s, hold_s, sclk_s, sdi_s} = pins_s;

  edge_t cs_e, sclk_e;
  logic  cs_rise, cs_fall;

  spi_fe_edge #(.RST_VAL(1'b0)) i_cs_edge   (.clk_i, .rst_ni, .lvl_i(cs_s),   .edge_o(cs_e));
  spi_fe_edge #(.RST_VAL(1'b0)) i_sclk_edge (.clk_i, .rst_ni, .lvl_i(sclk_s), .edge_o(sclk_e));

  assign cs_rise = cs_e.rise;
  assign cs_fall = cs_e.fall;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (cs_fall) armed_q <= 1'b1;
  end

  logic active, held, go, clr;
  assign active   = armed_q & ~cs_s;
  assign held     = ~hold_s & ~quad_en_i;
  assign go       = active & ~held;
  assign clr      = cs_rise | cs_fall;
  assign sdo_oe_o = go;

  logic [CNT_W-1:0] bit_cnt;

  spi_fe_rx #(.DATA_W(DATA_W)) i_rx (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .en_i   (sclk_e.rise & go),
    .bit_i  (sdi_s),
    .data_o (rx_byte_o),
    .valid_o(byte_valid_o),
    .cnt_o  (bit_cnt)
  );

  spi_fe_tx #(.DATA_W(DATA_W)) i_tx (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .shift_i(sclk_e.fall & go),
    .data_i (tx_byte_i),
    .sdo_o  (sdo_o)
  );
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic             cs_rise,
  input logic             cs_fall,
  input logic             armed_q,
  input logic             active,
  input logic             held,
  input logic             quad_en_i,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             byte_valid_o,
  input logic             sdo_o,
  input logic             sdo_oe_o
);
  assert_deselect_hiz_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> !sdo_oe_o);

  assert_no_output_unarmed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (!byte_valid_o && !sdo_oe_o));

  assert_valid_single_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  assert_hold_freezes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && held && !cs_fall) |=> ($stable(bit_cnt) && $stable(sdo_o) && !byte_valid_o));

  assert_hold_hiz_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && held) |-> !sdo_oe_o);

  assert_quad_ignores_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && quad_en_i) |-> sdo_oe_o);

  assert_abort_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (bit_cnt == '0));
endmodule

bind spi_front_end spi_fe_checker #(.CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_s         (cs_s),
  .cs_rise      (cs_rise),
  .cs_fall      (cs_fall),
  .armed_q      (armed_q),
  .active       (active),
  .held         (held),
  .quad_en_i    (quad_en_i),
  .bit_cnt      (bit_cnt),
  .byte_valid_o (byte_valid_o),
  .sdo_o        (sdo_o),
  .sdo_oe_o     (sdo_oe_o)
);

// File: tb/test_spi_front_end.sv
module test_spi_front_end;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sclk = 1'b0, sdi = 1'b0, hold_n = 1'b1, quad_en = 1'b0;
  logic [7:0] tx_byte = '0;
  logic [7:0] rx_byte;
  logic byte_valid, sdo, sdo_oe;

  int checks = 0, fails = 0;
  logic [7:0] exp_q [$];
  bit expect_none = 1'b0;

  always #2.5 clk = ~clk;

  spi_front_end i_spi_front_end (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .hold_ni(hold_n), .quad_en_i(quad_en), .tx_byte_i(tx_byte),
    .rx_byte_o(rx_byte), .byte_valid_o(byte_valid), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard of received bytes (R3, R2)
  always @(negedge clk) begin
    if (rst_n && byte_valid) begin
      if (exp_q.size() == 0 || expect_none) begin
        checks++; fails++;
        $display("FAIL R2/R3: unexpected byte %0h, expected none", rx_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_byte == e, "R3 rx byte", rx_byte, e);
      end
    end
  end

  // drives one byte; pause_at < 8 inserts a hold before that bit
  task automatic xfer(input logic [7:0] rx, input logic [7:0] tx, input int pause_at,
                      input bit push, input bit chk_tx);
    logic prev;
    if (push) exp_q.push_back(rx);
    tx_byte = tx;
    for (int i = 7; i >= 0; i--) begin
      if (7 - i == pause_at) begin
        prev = sdo;
        hold_n = 1'b0;
        wclk(HALF);
        chk(sdo_oe == (quad_en ? 1'b1 : 1'b0), quad_en ? "R7 oe in quad" : "R5 oe in hold",
            sdo_oe, quad_en);
        if (!quad_en) begin
          for (int g = 0; g < 3; g++) begin
            sdi = ~sdi; sclk = 1'b1; wclk(HALF);
            sclk = 1'b0; wclk(HALF);
          end
          chk(sdo == prev, "R5 sdo frozen", sdo, prev);
          hold_n = 1'b1;
          wclk(HALF);
          chk(sdo_oe == 1'b1, "R6 oe resumes", sdo_oe, 1);
        end
      end
      sdi = rx[i];
      wclk(HALF);
      prev = sdo;
      sclk = 1'b1;
      wclk(HALF);
      if (chk_tx) chk(sdo == prev, "R4 sdo stable after rise", sdo, prev);
      sclk = 1'b0;
      wclk(HALF);
      if (chk_tx) chk(sdo == tx[i], "R4 sdo bit", sdo, tx[i]);
    end
  endtask

  task automatic select;
    cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic deselect;
    cs_n = 1'b1;
    wclk(HALF);
  endtask

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(HALF);
    chk(byte_valid == 0 && sdo_oe == 0, "R2 reset state", {byte_valid, sdo_oe}, 0);

    // R2: cs low through reset, no edge -> nothing
    expect_none = 1'b1;
    xfer(8'hA5, 8'h00, 8, 1'b0, 1'b0);
    chk(sdo_oe == 0, "R2 oe without select edge", sdo_oe, 0);
    expect_none = 1'b0;

    deselect;
    chk(sdo_oe == 0, "R1 oe deselected", sdo_oe, 0);
    select;
    chk(sdo_oe == 1, "R9 oe selected", sdo_oe, 1);
    chk(sdo == 0, "R4 sdo after select", sdo, 0);

    xfer(8'h3C, 8'h96, 8, 1'b1, 1'b1);
    xfer(8'hFF, 8'h01, 8, 1'b1, 1'b1);
    xfer(8'h00, 8'hFE, 8, 1'b1, 1'b1);

    // R5/R6: pause mid-byte
    xfer(8'h5A, 8'hC3, 3, 1'b1, 1'b1);
    xfer(8'h81, 8'h7E, 7, 1'b1, 1'b1);

    // R8: abort partial byte
    deselect;
    select;
    exp_q.push_back(8'hE7);
    tx_byte = 8'h00;
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0; wclk(HALF);
    end
    deselect;
    chk(sdo_oe == 0, "R1 oe after abort", sdo_oe, 0);
    select;
    chk(sdo == 0, "R8 sdo cleared", sdo, 0);
    xfer(8'hE7, 8'h2D, 8, 1'b0, 1'b1);

    // R7: quad mode ignores hold
    quad_en = 1'b1;
    xfer(8'h69, 8'hB4, 2, 1'b1, 1'b1);
    hold_n = 1'b0;
    wclk(HALF);
    xfer(8'h12, 8'h48, 8, 1'b1, 1'b1);
    chk(sdo_oe == 1, "R7 oe with hold low", sdo_oe, 1);
    hold_n = 1'b1;
    quad_en = 1'b0;

    deselect;
    chk(sdo_oe == 0, "R1 final deselect", sdo_oe, 0);
    wclk(HALF);
    chk(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule